// File: doc/BRIEF.md
# Dithered Sub-Cycle PWM Generator

This block drives a single pulse-width-modulated output from an 8-bit duty value and runs straight off the system clock. A full PWM cycle lasts 256 clocks, so the average high fraction is the duty value divided by 256. The block splits each full cycle into equal modulation sub-cycles to raise the ripple frequency. It either splits the cycle in two (two 128-clock sub-cycles) or in four (four 64-clock sub-cycles).

The upper duty bits set a base high length for every sub-cycle. The low duty bits choose how many of the leading sub-cycles get one extra high clock. This keeps the full 8-bit resolution of the average while the output toggles two or four times faster.

Duty and split mode are captured only at the start of a full cycle, so no sub-cycle is ever built from a mix of old and new settings. Clearing the enable parks the counter and forces the output low. Setting it again starts a fresh cycle from sub-cycle 0.

Top module: `dither_pwm`

## Requirements
- R1: While reset is asserted and right after it is released, `pwmOut` is low and the cycle position is zero.
- R2: While `enableIn` is high, the cycle position advances by one per clock and wraps after 256 clocks. `pwmOut` is registered: the level for position p appears one clock after the edge that processes p, and position 0 is shown on the first clock after enabling.
- R3: With `modeSel`=1 (four sub-cycles), sub-cycle i covers positions 64i..64i+63. Its base count is duty bits 7..2 and its spread count is duty bits 1..0. Sub-cycle i is high for base+1 clocks when i < spread, and for base clocks otherwise.
- R4: With `modeSel`=0 (two sub-cycles), sub-cycle 0 covers positions 0..127 and sub-cycle 1 covers positions 128..255. The base count is duty bits 7..1 and the spread count is bit 0. Sub-cycle 0 is high for base+spread clocks and sub-cycle 1 for base clocks.
- R5: In either mode, the number of high clocks over one full cycle equals the duty value.
- R6: `dutyIn` and `modeSel` are sampled only at the edge that processes position 0. Changes at any other time take effect from the next full cycle.
- R7: Each sub-cycle is high first, for its computed count, then low for the rest. A count of zero gives a sub-cycle with no high clock, and a duty of 0 keeps the output low for the whole cycle.
- R8: When `enableIn` is low, `pwmOut` is low from the next clock and the position is held at zero. On re-enable, output restarts at position 0 with a freshly sampled duty and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one PWM step per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| enableIn | input | 1 | Channel enable; low parks the counter and clears the output |
| modeSel | input | 1 | Split select: 0 = two sub-cycles, 1 = four sub-cycles |
| dutyIn | input | DUTY_W (8) | Duty value, sampled at the start of each full cycle |
| pwmOut | output | 1 | Registered PWM output |

## Verification
The bench builds the block with its default 8-bit duty width, so a full cycle is 256 clocks. At this width every position of a cycle can be compared against an independent model of the sub-cycle rule. The vector walk runs cycles back to back and covers both split modes, duty values 0 and 255, each spread count from 1 to 3, and odd and even duty values in the two-way mode. This brings every spread pattern and the period wrap within reach. Directed runs change the duty in mid-cycle, and also drop and raise the enable in mid-cycle, to show that settings are latched only at cycle start and that counting restarts from position 0.

// File: rtl/pwm_split_pkg.sv
package pwm_split_pkg;

  // Split selection: two sub-cycles or four sub-cycles per full cycle.
  typedef enum logic {
    SPLIT_HALF    = 1'b0,
    SPLIT_QUARTER = 1'b1
  } splitMode_e;

  // Strobes from the sequencing control to the waveform datapath.
  typedef struct packed {
    logic clear;  // park: output low, nothing latched
    logic load;   // start of a full cycle: capture duty and mode
    logic step;   // an active position is being processed this clock
  } pwmStrobe_t;

  localparam int NUM_MODES = 2;

endpackage

// File: rtl/pwm_seq_ctrl.sv
module pwm_seq_ctrl
  import pwm_split_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enableIn,
  output logic [DUTY_W-1:0] cyclePos,
  output pwmStrobe_t        strobes
);

  localparam logic [DUTY_W-1:0] POS_ZERO = '0;
  localparam logic [DUTY_W-1:0] POS_ONE  = DUTY_W'(1);

  logic [DUTY_W-1:0] posQ;

  // Position counter: free-running modulo 2^DUTY_W while enabled, parked at zero otherwise.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posQ <= POS_ZERO;
    end else if (!enableIn) begin
      posQ <= POS_ZERO;
    end else begin
      posQ <= posQ + POS_ONE;
    end
  end

  always_comb begin
    strobes.clear = !enableIn;
    strobes.step  = enableIn;
    strobes.load  = enableIn && (posQ == POS_ZERO);
  end

  assign cyclePos = posQ;

endmodule

// File: rtl/pwm_sub_slicer.sv
module pwm_sub_slicer #(
  parameter int DUTY_W     = 8,
  parameter int SPLIT_BITS = 2
) (
  input  logic [DUTY_W-1:0] duty,
  input  logic [DUTY_W-1:0] pos,
  output logic              highNow
);

  // Width of the base count and of the offset inside one sub-cycle.
  localparam int CW = DUTY_W - SPLIT_BITS;

  logic [CW-1:0]         baseCnt;
  logic [SPLIT_BITS-1:0] spreadCnt;
  logic [SPLIT_BITS-1:0] subIdx;
  logic [CW-1:0]         offset;
  logic                  extraClk;
  logic [CW:0]           highLen;

  always_comb begin
    baseCnt   = duty[DUTY_W-1:SPLIT_BITS];
    spreadCnt = duty[SPLIT_BITS-1:0];
    subIdx    = pos[DUTY_W-1:CW];
    offset    = pos[CW-1:0];
    // The leading sub-cycles, one per unit of spread, get one extra high clock.
    extraClk  = (subIdx < spreadCnt);
    highLen   = {1'b0, baseCnt} + {{CW{1'b0}}, extraClk};
    // High first, then low for the remainder of the sub-cycle.
    highNow   = ({1'b0, offset} < highLen);
  end

endmodule

// File: rtl/pwm_wave_dp.sv
module pwm_wave_dp
  import pwm_split_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwmStrobe_t        strobes,
  input  logic [DUTY_W-1:0] cyclePos,
  input  logic [DUTY_W-1:0] dutyIn,
  input  splitMode_e        modeIn,
  output logic [DUTY_W-1:0] dutyHeld,
  output logic              pwmOut
);

  logic [DUTY_W-1:0]    dutyQ;
  splitMode_e           modeQ;
  logic [DUTY_W-1:0]    dutyEff;
  splitMode_e           modeEff;
  logic [NUM_MODES-1:0] highVec;
  logic                 highSel;
  logic                 outQ;

  // Settings in force: the fresh inputs at cycle start, the held copy elsewhere.
  always_comb begin
    dutyEff = strobes.load ? dutyIn : dutyQ;
    modeEff = strobes.load ? modeIn : modeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyQ <= '0;
      modeQ <= SPLIT_HALF;
    end else if (strobes.load) begin
      dutyQ <= dutyIn;
      modeQ <= modeIn;
    end
  end

  // One slicer per split mode; mode m uses m+1 spread bits.
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_slice
    pwm_sub_slicer #(
      .DUTY_W    (DUTY_W),
      .SPLIT_BITS(m + 1)
    ) u_slice (
      .duty   (dutyEff),
      .pos    (cyclePos),
      .highNow(highVec[m])
    );
  end

  always_comb begin
    highSel = (modeEff == SPLIT_QUARTER) ? highVec[1] : highVec[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ <= 1'b0;
    end else if (strobes.clear) begin
      outQ <= 1'b0;
    end else begin
      outQ <= strobes.step && highSel;
    end
  end

  assign pwmOut   = outQ;
  assign dutyHeld = dutyQ;

endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
  import pwm_split_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enableIn,
  input  logic              modeSel,
  input  logic [DUTY_W-1:0] dutyIn,
  output logic              pwmOut
);

  pwmStrobe_t        strobes;
  logic [DUTY_W-1:0] cyclePos;
  logic [DUTY_W-1:0] dutyHeld;
  splitMode_e        modeIn;

  assign modeIn = splitMode_e'(modeSel);

  pwm_seq_ctrl #(
    .DUTY_W(DUTY_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enableIn(enableIn),
    .cyclePos(cyclePos),
    .strobes (strobes)
  );

  pwm_wave_dp #(
    .DUTY_W(DUTY_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .cyclePos(cyclePos),
    .dutyIn  (dutyIn),
    .modeIn  (modeIn),
    .dutyHeld(dutyHeld),
    .pwmOut  (pwmOut)
  );

endmodule

// File: rtl/dither_pwm_checker.sv
module dither_pwm_checker #(
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enableIn,
  input logic [DUTY_W-1:0] dutyIn,
  input logic              pwmOut,
  input logic [DUTY_W-1:0] cyclePos,
  input logic [DUTY_W-1:0] dutyHeld
);

  localparam logic [DUTY_W-1:0] POS_ZERO = '0;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    enableIn |=> (cyclePos == DUTY_W'($past(cyclePos) + 1'b1)));

  assert_first_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enableIn && cyclePos == POS_ZERO && dutyIn != POS_ZERO) |=> pwmOut);

  assert_hold_mid_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enableIn && cyclePos != POS_ZERO) |=> $stable(dutyHeld));

  assert_zero_duty_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enableIn && cyclePos == POS_ZERO && dutyIn == POS_ZERO) |=> !pwmOut);

  assert_park_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enableIn |=> !pwmOut);

  assert_park_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enableIn |=> (cyclePos == POS_ZERO));

endmodule

bind dither_pwm dither_pwm_checker #(.DUTY_W(DUTY_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .enableIn(enableIn),
  .dutyIn  (dutyIn),
  .pwmOut  (pwmOut),
  .cyclePos(cyclePos),
  .dutyHeld(dutyHeld)
);

// File: tb/dither_pwm_bench.sv
module dither_pwm_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CYC = 256;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enableIn = 1'b0;
  logic       modeSel = 1'b0;
  logic [7:0] dutyIn = 8'h00;
  logic       pwmOut;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dither_pwm #(.DUTY_W(8)) u_dither_pwm (
    .clk     (clk),
    .rstN    (rstN),
    .enableIn(enableIn),
    .modeSel (modeSel),
    .dutyIn  (dutyIn),
    .pwmOut  (pwmOut)
  );

  typedef struct packed {
    logic [7:0] duty;
    logic       quarter;
    logic [8:0] sub0High;
  } vec_t;

  // duty, mode (1 = four sub-cycles), expected high clocks in sub-cycle 0
  localparam vec_t VECS[12] = '{
    '{8'h00, 1'b1, 9'd0},
    '{8'hFF, 1'b1, 9'd64},
    '{8'h01, 1'b1, 9'd1},
    '{8'h02, 1'b1, 9'd1},
    '{8'h03, 1'b1, 9'd1},
    '{8'h81, 1'b1, 9'd33},
    '{8'h4E, 1'b1, 9'd20},
    '{8'h00, 1'b0, 9'd0},
    '{8'hFF, 1'b0, 9'd128},
    '{8'h01, 1'b0, 9'd1},
    '{8'h80, 1'b0, 9'd64},
    '{8'h7F, 1'b0, 9'd64}
  };

  // Independent model of the sub-cycle rule from the requirements.
  function automatic int expBit(int p, int duty, bit quarter);
    int split = quarter ? 2 : 1;
    int subLen = CYC >> split;
    int sub = p / subLen;
    int off = p % subLen;
    int base = duty >> split;
    int spread = duty & ((1 << split) - 1);
    int len = base + ((sub < spread) ? 1 : 0);
    return (off < len) ? 1 : 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Samples one full cycle from position 0; optional mid-cycle input change at chgPos.
  task automatic runCycle(input int duty, input bit quarter, input int chgPos,
                          input int newDuty, input bit newMode,
                          output int mism, output int total, output int sub0);
    int subLen = quarter ? 64 : 128;
    mism = 0; total = 0; sub0 = 0;
    for (int p = 0; p < CYC; p++) begin
      @(negedge clk);
      if (int'(pwmOut) != expBit(p, duty, quarter)) mism++;
      total += int'(pwmOut);
      if (p < subLen) sub0 += int'(pwmOut);
      if (p == chgPos) begin
        dutyIn  = 8'(newDuty);
        modeSel = newMode;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int mism, total, sub0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(pwmOut == 1'b0, "R1 out during reset", int'(pwmOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(pwmOut == 1'b0, "R1 out after reset", int'(pwmOut), 0);
    dutyIn = 8'hFF;
    modeSel = 1'b1;
    repeat (4) @(negedge clk);
    check(pwmOut == 1'b0, "R8 disabled stays low", int'(pwmOut), 0);

    // Vector walk: back-to-back full cycles.
    dutyIn   = VECS[0].duty;
    modeSel  = VECS[0].quarter;
    enableIn = 1'b1;
    for (int v = 0; v < 12; v++) begin
      dutyIn  = VECS[v].duty;
      modeSel = VECS[v].quarter;
      runCycle(VECS[v].duty, VECS[v].quarter, -1, 0, 1'b0, mism, total, sub0);
      check(mism == 0, VECS[v].quarter ? "R3 R7 R2 trace" : "R4 R7 R2 trace", mism, 0);
      check(sub0 == int'(VECS[v].sub0High), VECS[v].quarter ? "R3 sub0 high" : "R4 sub0 high",
            sub0, int'(VECS[v].sub0High));
      check(total == int'(VECS[v].duty), "R5 total high", total, int'(VECS[v].duty));
    end

    // R6: a mid-cycle change is ignored until the next cycle start.
    dutyIn  = 8'h40;
    modeSel = 1'b1;
    runCycle(8'h40, 1'b1, 100, 8'hC5, 1'b0, mism, total, sub0);
    check(mism == 0, "R6 old settings kept in cycle", mism, 0);
    check(total == 8'h40, "R6 old duty total", total, 8'h40);
    runCycle(8'hC5, 1'b0, -1, 0, 1'b0, mism, total, sub0);
    check(mism == 0, "R6 new settings next cycle", mism, 0);
    check(total == 8'hC5, "R6 new duty total", total, 8'hC5);

    // R8: drop enable mid-cycle, then restart from position 0.
    dutyIn  = 8'hFF;
    modeSel = 1'b1;
    for (int p = 0; p < 50; p++) @(negedge clk);
    enableIn = 1'b0;
    @(negedge clk);
    check(pwmOut == 1'b0, "R8 low after disable", int'(pwmOut), 0);
    mism = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (pwmOut != 1'b0) mism++;
    end
    check(mism == 0, "R8 held low while disabled", mism, 0);
    dutyIn  = 8'h03;
    modeSel = 1'b1;
    enableIn = 1'b1;
    runCycle(8'h03, 1'b1, -1, 0, 1'b0, mism, total, sub0);
    check(mism == 0, "R8 restart from position 0", mism, 0);
    check(total == 3, "R8 fresh duty total", total, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule